// File: doc/BRIEF.md
# Display Controller Serial Register Slave

This block is the two-wire serial front end of a multiplexed LED display controller. It watches the serial clock and data lines with a fast system clock. Both lines pass through a synchronizer and a glitch filter. The block then recognizes START, repeated START and STOP and runs a byte-level slave state machine. The 7-bit device address is five fixed zero bits followed by two run-time bits. Those two bits are zero after reset and can be loaded from two strap inputs by a self-address command. Up to four controllers can therefore share one bus.

In a write, the byte after the address is a command byte that loads the register pointer. Each following byte is stored at the pointer, and the pointer then steps by one. A read returns the byte at the pointer, steps the pointer after each byte, and continues until the master answers with a not-acknowledge. The register file holds the eight digit registers, decode enable, global intensity, scan limit, shutdown, feature, test, four digit-pair intensity registers and the self-address register. It also returns read-only diagnostic and key bytes that other logic supplies. Some writes have side effects:
- A global intensity write is copied into every digit-pair intensity register.
- A shutdown write can clear the feature register.
- A feature write can return the control registers to their defaults.

States of the bus engine:
- `ST_IDLE`
- `ST_ADDR` (address shift-in)
- `ST_ADDR_ACK`
- `ST_CMD` (command shift-in)
- `ST_CMD_ACK`
- `ST_WDAT` (data shift-in)
- `ST_WDAT_ACK`
- `ST_RDAT` (data shift-out)
- `ST_RDAT_CHK` (master acknowledge sample)

Transitions:
- START or repeated START, from any state: to `ST_ADDR`.
- STOP, from any state: to `ST_IDLE`.
- `ST_ADDR`, after eight bits and a falling clock: to `ST_ADDR_ACK` on an address match, otherwise to `ST_IDLE`.
- `ST_ADDR_ACK`: to `ST_RDAT` when the direction bit is 1, otherwise to `ST_CMD`.
- `ST_CMD` to `ST_CMD_ACK`, then to `ST_WDAT`.
- `ST_WDAT` and `ST_WDAT_ACK` alternate while the master keeps writing.
- `ST_RDAT`: to `ST_RDAT_CHK` after eight bits.
- `ST_RDAT_CHK`: to `ST_RDAT` on a master acknowledge, otherwise to `ST_IDLE`.

Top module: `disp_i2c_regslave`

## Requirements
- R1: The block acknowledges (drives `sda_oe_o` high in the ninth bit) only an address byte whose upper seven bits equal {5'b00000, A1, A0}. For any other address it does not acknowledge, and the rest of the transfer has no effect.
- R2: In a write, the first byte after the address loads the register pointer. Each further byte is written at the pointer, and the pointer then increments by one. Every written byte is acknowledged.
- R3: A read (direction bit 1) shifts out, MSB first, the register at the pointer and increments the pointer after each byte. A master acknowledge continues the read. A master not-acknowledge ends it with SDA released (`sda_oe_o` = 0).
- R4: Register map:
  - digits 0..7: 0x01..0x08
  - decode enable: 0x09
  - global intensity: 0x0A
  - scan limit: 0x0B
  - shutdown: 0x0C
  - feature: 0x0E
  - test: 0x0F
  - digit-pair intensity 0..3: 0x10..0x13
  - self-address: 0x2D
  - diagnostic n (read-only): 0x14+n, returns `diag_i[8n+7:8n]`
  - key (read-only): 0x1C, returns `key_i`

  Unmapped addresses read as 0x00. Writes to unmapped or read-only addresses are acknowledged and change nothing.
- R5: A write of value v to 0x0A also loads {v[3:0], v[3:0]} into all four digit-pair intensity registers.
- R6: A write to one digit-pair intensity register (0x10+p, output bits `inten_o[8p+7:8p]`) leaves the other three unchanged.
- R7: A write to 0x0C drives `run_o` from bit 0, where 1 means normal operation and 0 means shutdown. When bit 7 is 0 the feature register is cleared to 0x00. When bit 7 is 1 the feature register is kept.
- R8: A write to 0x0E with bit 1 set stores the written value in the feature register. It also clears decode enable, global intensity, scan limit, shutdown, test and all pair intensities to zero, and leaves the digit registers unchanged.
- R9: A write to 0x2D with bit 0 = 1 sets A1 = `strap_a1_i` and A0 = `strap_a0_i`, where an open strap reads as 1 and a shorted strap as 0. Bit 0 = 0 returns A1 and A0 to 00.
- R10: While `rst_n` is low, every register, including A1/A0, returns to zero. `run_o` is then 0 (shutdown) until a shutdown-register write sets bit 0.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks (default 4) is ignored.
- R12: A repeated START inside a transfer restarts the address phase without a STOP in between. A STOP returns the engine to idle from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset of all registers |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| strap_a1_i | input | 1 | Strap level loaded into A1 |
| strap_a0_i | input | 1 | Strap level loaded into A0 |
| key_i | input | 8 | Debounced key byte (register 0x1C) |
| diag_i | input | 64 | LED diagnostic bytes, digit n at [8n+7:8n] |
| digits_o | output | 64 | Digit registers, digit n at [8n+7:8n] |
| decode_o | output | 8 | Decode enable per digit |
| inten_o | output | 32 | Pair intensities, pair p at [8p+7:8p] |
| scan_o | output | 8 | Scan limit register |
| run_o | output | 1 | 1 = normal operation, 0 = shutdown |
| feature_o | output | 8 | Feature register |
| test_o | output | 8 | Test register |

## Verification
Committing a received data byte and stepping the pointer happen on the same falling SCL edge. A write to the global intensity register also updates four other registers in that same cycle. Both are provoked by a three-byte burst write. The result is judged by reading every landed byte back in a burst read, and by comparing all pair intensities after a global write followed by a single pair write. A shutdown write clears the feature register in the cycle it is stored, so `run_o` and `feature_o` are compared together after each of the write variants. A feature write with bit 1 set resets six registers at once, which is judged against the unchanged digit outputs.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_CHK
    } bus_state_e;

    localparam logic [7:0] REG_DIG0   = 8'h01;
    localparam logic [7:0] REG_DECODE = 8'h09;
    localparam logic [7:0] REG_GINT   = 8'h0A;
    localparam logic [7:0] REG_SCAN   = 8'h0B;
    localparam logic [7:0] REG_SHDN   = 8'h0C;
    localparam logic [7:0] REG_FEAT   = 8'h0E;
    localparam logic [7:0] REG_TEST   = 8'h0F;
    localparam logic [7:0] REG_PINT0  = 8'h10;
    localparam logic [7:0] REG_DIAG0  = 8'h14;
    localparam logic [7:0] REG_KEY    = 8'h1C;
    localparam logic [7:0] REG_SELF   = 8'h2D;

    localparam int SHDN_KEEP_BIT = 7;
    localparam int SHDN_RUN_BIT  = 0;
    localparam int FEAT_RST_BIT  = 1;
    localparam int SELF_EN_BIT   = 0;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == clean_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                clean_o <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import disp_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_lsb_i,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic [7:0] ptr_o,
    output bus_state_e state_o
);
    localparam logic [3:0] BITS_RX = 4'd8;
    localparam logic [3:0] BITS_TX = 4'd7;

    bus_state_e st_q, st_d;
    logic       scl_d, sda_d;
    logic [7:0] shift_q;
    logic [3:0] cnt_q;
    logic       rw_q, mack_q;

    wire scl_rise = scl_i & ~scl_d;
    wire scl_fall = ~scl_i & scl_d;
    wire start_c  = scl_i & scl_d & sda_d & ~sda_i;
    wire stop_c   = scl_i & scl_d & ~sda_d & sda_i;
    wire addr_hit = (shift_q[7:1] == {5'b00000, dev_lsb_i});
    wire byte_end = scl_fall && (cnt_q == BITS_RX);

    // next-state decision
    always_comb begin
        st_d = st_q;
        if (start_c) begin
            st_d = ST_ADDR;
        end else if (stop_c) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:     st_d = ST_IDLE;
                ST_ADDR:     if (byte_end) st_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) st_d = rw_q ? ST_RDAT : ST_CMD;
                ST_CMD:      if (byte_end) st_d = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) st_d = ST_WDAT;
                ST_WDAT:     if (byte_end) st_d = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) st_d = ST_WDAT;
                ST_RDAT:     if (scl_fall && cnt_q == BITS_TX) st_d = ST_RDAT_CHK;
                ST_RDAT_CHK: if (scl_fall) st_d = mack_q ? ST_RDAT : ST_IDLE;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // bit engine, pointer and write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
            shift_q   <= '0;
            cnt_q     <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            ptr_o     <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            scl_d   <= scl_i;
            sda_d   <= sda_i;
            wr_en_o <= 1'b0;
            if (start_c) begin
                cnt_q <= '0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_CMD, ST_WDAT: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[6:0], sda_i};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (byte_end) begin
                            cnt_q <= '0;
                            if (st_q == ST_ADDR) rw_q <= shift_q[0];
                            if (st_q == ST_CMD)  ptr_o <= shift_q;
                            if (st_q == ST_WDAT) begin
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= ptr_o;
                                wr_data_o <= shift_q;
                                ptr_o     <= ptr_o + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) shift_q <= rd_data_i;
                        end
                    end
                    ST_CMD_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) cnt_q <= '0;
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (cnt_q == BITS_TX) begin
                                cnt_q <= '0;
                                ptr_o <= ptr_o + 1'b1;
                            end else begin
                                shift_q <= {shift_q[6:0], 1'b0};
                                cnt_q   <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RDAT_CHK: begin
                        if (scl_rise) mack_q <= ~sda_i;
                        if (scl_fall && mack_q) shift_q <= rd_data_i;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
            ST_RDAT:                              sda_oe_o = ~shift_q[7];
            default:                              sda_oe_o = 1'b0;
        endcase
    end

    assign state_o = st_q;
endmodule

// File: rtl/disp_regfile.sv
module disp_regfile
    import disp_i2c_pkg::*;
#(
    parameter int NUM_DIGITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [7:0]              wr_addr_i,
    input  logic [7:0]              wr_data_i,
    input  logic [7:0]              rd_addr_i,
    output logic [7:0]              rd_data_o,
    input  logic                    strap_a1_i,
    input  logic                    strap_a0_i,
    input  logic [7:0]              key_i,
    input  logic [NUM_DIGITS*8-1:0] diag_i,
    output logic [1:0]              dev_lsb_o,
    output logic [NUM_DIGITS*8-1:0] digits_o,
    output logic [7:0]              decode_o,
    output logic [NUM_DIGITS*4-1:0] inten_o,
    output logic [7:0]              scan_o,
    output logic                    run_o,
    output logic [7:0]              feature_o,
    output logic [7:0]              test_o
);
    localparam int NUM_PAIRS = NUM_DIGITS / 2;

    logic [7:0] dig_q  [NUM_DIGITS];
    logic [7:0] pint_q [NUM_PAIRS];
    logic [7:0] decode_q, gint_q, scan_q, shdn_q, feat_q, test_q, self_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DIGITS; i++) dig_q[i] <= '0;
            for (int p = 0; p < NUM_PAIRS; p++) pint_q[p] <= '0;
            decode_q  <= '0;
            gint_q    <= '0;
            scan_q    <= '0;
            shdn_q    <= '0;
            feat_q    <= '0;
            test_q    <= '0;
            self_q    <= '0;
            dev_lsb_o <= 2'b00;
        end else if (wr_en_i) begin
            for (int i = 0; i < NUM_DIGITS; i++)
                if (wr_addr_i == 8'(REG_DIG0 + i)) dig_q[i] <= wr_data_i;
            for (int p = 0; p < NUM_PAIRS; p++)
                if (wr_addr_i == 8'(REG_PINT0 + p)) pint_q[p] <= wr_data_i;
            case (wr_addr_i)
                REG_DECODE: decode_q <= wr_data_i;
                REG_GINT: begin
                    gint_q <= wr_data_i;
                    for (int p = 0; p < NUM_PAIRS; p++)
                        pint_q[p] <= {wr_data_i[3:0], wr_data_i[3:0]};
                end
                REG_SCAN: scan_q <= wr_data_i;
                REG_SHDN: begin
                    shdn_q <= wr_data_i;
                    if (!wr_data_i[SHDN_KEEP_BIT]) feat_q <= '0;
                end
                REG_FEAT: begin
                    feat_q <= wr_data_i;
                    if (wr_data_i[FEAT_RST_BIT]) begin
                        decode_q <= '0;
                        gint_q   <= '0;
                        scan_q   <= '0;
                        shdn_q   <= '0;
                        test_q   <= '0;
                        for (int p = 0; p < NUM_PAIRS; p++) pint_q[p] <= '0;
                    end
                end
                REG_TEST: test_q <= wr_data_i;
                REG_SELF: begin
                    self_q    <= wr_data_i;
                    dev_lsb_o <= wr_data_i[SELF_EN_BIT] ? {strap_a1_i, strap_a0_i} : 2'b00;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (rd_addr_i == 8'(REG_DIG0 + i))  rd_data_o = dig_q[i];
            if (rd_addr_i == 8'(REG_DIAG0 + i)) rd_data_o = diag_i[8*i +: 8];
        end
        for (int p = 0; p < NUM_PAIRS; p++)
            if (rd_addr_i == 8'(REG_PINT0 + p)) rd_data_o = pint_q[p];
        case (rd_addr_i)
            REG_DECODE: rd_data_o = decode_q;
            REG_GINT:   rd_data_o = gint_q;
            REG_SCAN:   rd_data_o = scan_q;
            REG_SHDN:   rd_data_o = shdn_q;
            REG_FEAT:   rd_data_o = feat_q;
            REG_TEST:   rd_data_o = test_q;
            REG_KEY:    rd_data_o = key_i;
            REG_SELF:   rd_data_o = self_q;
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        assign digits_o[8*g +: 8] = dig_q[g];
    end
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pint
        assign inten_o[8*g +: 8] = pint_q[g];
    end

    assign decode_o  = decode_q;
    assign scan_o    = scan_q;
    assign run_o     = shdn_q[SHDN_RUN_BIT];
    assign feature_o = feat_q;
    assign test_o    = test_q;
endmodule

// File: rtl/disp_i2c_regslave.sv
module disp_i2c_regslave
    import disp_i2c_pkg::*;
#(
    parameter int FILT_LEN   = 4,
    parameter int NUM_DIGITS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe_o,
    input  logic                    strap_a1_i,
    input  logic                    strap_a0_i,
    input  logic [7:0]              key_i,
    input  logic [NUM_DIGITS*8-1:0] diag_i,
    output logic [NUM_DIGITS*8-1:0] digits_o,
    output logic [7:0]              decode_o,
    output logic [NUM_DIGITS*4-1:0] inten_o,
    output logic [7:0]              scan_o,
    output logic                    run_o,
    output logic [7:0]              feature_o,
    output logic [7:0]              test_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines, clean_lines;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, ptr, rd_data;
    logic [1:0] dev_lsb;
    bus_state_e bus_st;

    assign raw_lines = {sda_i, scl_i};

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[l]),
            .clean_o (clean_lines[l])
        );
    end

    i2c_slave_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (clean_lines[0]),
        .sda_i     (clean_lines[1]),
        .dev_lsb_i (dev_lsb),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .ptr_o     (ptr),
        .state_o   (bus_st)
    );

    disp_regfile #(.NUM_DIGITS(NUM_DIGITS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (ptr),
        .rd_data_o  (rd_data),
        .strap_a1_i (strap_a1_i),
        .strap_a0_i (strap_a0_i),
        .key_i      (key_i),
        .diag_i     (diag_i),
        .dev_lsb_o  (dev_lsb),
        .digits_o   (digits_o),
        .decode_o   (decode_o),
        .inten_o    (inten_o),
        .scan_o     (scan_o),
        .run_o      (run_o),
        .feature_o  (feature_o),
        .test_o     (test_o)
    );
endmodule

// File: rtl/disp_i2c_regslave_chk.sv
module disp_i2c_regslave_chk
    import disp_i2c_pkg::*;
#(
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input bus_state_e       st,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [7:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic [7:0]       ptr,
    input logic [INT_W-1:0] inten,
    input logic [7:0]       feature,
    input logic             run
);
    localparam int NIB = INT_W / 4;

    // R1: no drive while the address is still being shifted in
    a_r1_quiet_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR) |-> !sda_oe);

    // R3: SDA released whenever the engine is idle
    a_r3_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R2: pointer has already stepped past the byte being committed
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == wr_addr + 8'd1));

    // R5: global intensity fans out to every pair nibble
    a_r5_global_fanout: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_GINT) |=> (inten == {NIB{$past(wr_data[3:0])}}));

    // R6: a pair write leaves pair 0 alone
    a_r6_pair_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'(REG_PINT0 + 8'd1)) |=> (inten[7:0] == $past(inten[7:0])));

    // R7: shutdown write with bit 7 low clears the feature register
    a_r7_feature_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SHDN && !wr_data[7]) |=> (feature == 8'h00));

    // R7: shutdown write with bit 7 high keeps the feature register
    a_r7_feature_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SHDN && wr_data[7]) |=> $stable(feature));

    // R8: feature reset forces shutdown
    a_r8_feature_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_FEAT && wr_data[1]) |=> !run);
endmodule

bind disp_i2c_regslave disp_i2c_regslave_chk #(.INT_W(NUM_DIGITS*4)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (bus_st),
    .sda_oe  (sda_oe_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ptr     (ptr),
    .inten   (inten_o),
    .feature (feature_o),
    .run     (run_o)
);

// File: tb/disp_i2c_regslave_tb.sv
`timescale 1ns/1ps
module disp_i2c_regslave_tb;
    localparam int Q = 8;          // system clocks per quarter SCL bit
    localparam int NVEC = 9;
    // {register, written byte, expected readback}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h01A5A5, 24'h083C3C, 24'h09F0F0, 24'h0B0707, 24'h0F0505,
        24'h119E9E, 24'h1C556B, 24'h0D7700, 24'h201100
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        strap_a1 = 1'b0, strap_a0 = 1'b0;
    logic [7:0]  key_v = 8'h6B;
    logic [63:0] diag_v = 64'h8877665544332211;
    logic        sda_oe;
    logic [63:0] digits;
    logic [7:0]  decode, scan, feature, test;
    logic [31:0] inten;
    logic        run;
    wire         sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    disp_i2c_regslave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_a1_i(strap_a1), .strap_a0_i(strap_a0), .key_i(key_v), .diag_i(diag_v),
        .digits_o(digits), .decode_o(decode), .inten_o(inten), .scan_o(scan),
        .run_o(run), .feature_o(feature), .test_o(test)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic bus_bit(input logic b, input bit glitch, output logic s);
        sda_m = b; wait_q();
        if (glitch) begin
            scl_m = 1'b1; repeat (2) @(negedge clk);
            scl_m = 1'b0; wait_q();
        end
        scl_m = 1'b1; wait_q();
        s = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic wbyte(input logic [7:0] b, input bit glitch, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], glitch, s);
        bus_bit(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, 1'b0, s);
            v[i] = s;
        end
        bus_bit(!mack, 1'b0, s);
    endtask

    task automatic reg_write(input logic [6:0] dev, input logic [7:0] ra,
                             input logic [7:0] d, input bit glitch);
        bit a;
        bus_start();
        wbyte({dev, 1'b0}, 1'b0, a);
        wbyte(ra, 1'b0, a);
        wbyte(d, glitch, a);
        bus_stop();
    endtask

    task automatic reg_read(input logic [6:0] dev, input logic [7:0] ra, output logic [7:0] v);
        bit a;
        bus_start();
        wbyte({dev, 1'b0}, 1'b0, a);
        wbyte(ra, 1'b0, a);
        bus_start();
        wbyte({dev, 1'b1}, 1'b0, a);
        rbyte(1'b0, v);
        bus_stop();
    endtask

    task automatic probe(input logic [6:0] dev, output bit ack);
        bus_start();
        wbyte({dev, 1'b0}, 1'b0, ack);
        bus_stop();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v1, v2;
        bit a, a1, a2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 reset state
        check("R10 digits", digits, 64'h0);
        check("R10 inten", {32'h0, inten}, 64'h0);
        check("R10 run", {63'h0, run}, 64'h0);
        check("R10 feature", {56'h0, feature}, 64'h0);
        check("R3 sda idle", {63'h0, sda_oe}, 64'h0);

        // R1 addressing
        probe(7'h00, a);  check("R1 ack addr 0", {63'h0, a}, 64'h1);
        probe(7'h01, a);  check("R1 nack addr 1", {63'h0, a}, 64'h0);
        probe(7'h40, a);  check("R1 nack addr 40", {63'h0, a}, 64'h0);

        // R2/R4 vector table: write then read back
        for (int k = 0; k < NVEC; k++) begin
            reg_write(7'h00, VEC[k][23:16], VEC[k][15:8], 1'b0);
            reg_read(7'h00, VEC[k][23:16], v);
            check($sformatf("R2 R4 reg %h", VEC[k][23:16]), {56'h0, v}, {56'h0, VEC[k][7:0]});
        end
        reg_read(7'h00, 8'h15, v);
        check("R4 diag1", {56'h0, v}, 64'h22);

        // R2 burst write with pointer increment
        bus_start();
        wbyte(8'h00, 1'b0, a);
        wbyte(8'h03, 1'b0, a);
        wbyte(8'h11, 1'b0, a);
        wbyte(8'h22, 1'b0, a1);
        wbyte(8'h33, 1'b0, a2);
        bus_stop();
        check("R2 data acks", {61'h0, a, a1, a2}, 64'h7);
        check("R2 burst", {40'h0, digits[39:16]}, 64'h332211);

        // R3/R12 burst read with repeated START and final NACK
        bus_start();
        wbyte(8'h00, 1'b0, a);
        wbyte(8'h03, 1'b0, a);
        bus_start();
        wbyte(8'h01, 1'b0, a);
        rbyte(1'b1, v);
        rbyte(1'b1, v1);
        rbyte(1'b0, v2);
        check("R3 R12 burst read", {40'h0, v, v1, v2}, 64'h112233);
        check("R3 released after nack", {63'h0, sda_oe}, 64'h0);
        bus_stop();

        // R5 global fan-out, R6 single pair
        reg_write(7'h00, 8'h0A, 8'h3B, 1'b0);
        check("R5 fanout", {32'h0, inten}, 64'hBBBBBBBB);
        reg_write(7'h00, 8'h12, 8'h47, 1'b0);
        check("R6 pair2 only", {32'h0, inten}, 64'hBB47BBBB);

        // R7 shutdown register
        reg_write(7'h00, 8'h0E, 8'hA4, 1'b0);
        reg_write(7'h00, 8'h0C, 8'h81, 1'b0);
        check("R7 run keep", {55'h0, run, feature}, {55'h0, 1'b1, 8'hA4});
        reg_write(7'h00, 8'h0C, 8'h80, 1'b0);
        check("R7 shut keep", {55'h0, run, feature}, {55'h0, 1'b0, 8'hA4});
        reg_write(7'h00, 8'h0C, 8'h01, 1'b0);
        check("R7 run clear", {55'h0, run, feature}, {55'h0, 1'b1, 8'h00});

        // R8 feature reset
        reg_write(7'h00, 8'h0E, 8'h02, 1'b0);
        check("R8 ctrl cleared", {23'h0, decode, scan, test, run, feature},
              {23'h0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h02});
        check("R8 inten cleared", {32'h0, inten}, 64'h0);
        check("R8 digits kept", digits, 64'h3C000033_221100A5);

        // R11 SCL glitch during a data byte
        reg_write(7'h00, 8'h02, 8'h5A, 1'b1);
        check("R11 glitch filtered", {56'h0, digits[15:8]}, 64'h5A);

        // R9 self-addressing
        strap_a1 = 1'b1; strap_a0 = 1'b0;
        reg_write(7'h00, 8'h2D, 8'h01, 1'b0);
        probe(7'h00, a);  check("R9 old addr nack", {63'h0, a}, 64'h0);
        probe(7'h02, a);  check("R9 new addr ack", {63'h0, a}, 64'h1);
        reg_read(7'h02, 8'h2D, v);
        check("R9 self reg", {56'h0, v}, 64'h01);
        strap_a1 = 1'b0; strap_a0 = 1'b1;
        reg_write(7'h02, 8'h2D, 8'h01, 1'b0);
        probe(7'h01, a);  check("R9 addr 1 ack", {63'h0, a}, 64'h1);
        reg_write(7'h01, 8'h2D, 8'h00, 1'b0);
        probe(7'h00, a);  check("R9 factory addr", {63'h0, a}, 64'h1);

        // R10 hardware reset mid-operation
        strap_a1 = 1'b1; strap_a0 = 1'b1;
        reg_write(7'h00, 8'h0C, 8'h81, 1'b0);
        reg_write(7'h00, 8'h2D, 8'h01, 1'b0);
        check("R10 run before reset", {63'h0, run}, 64'h1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 run after reset", {63'h0, run}, 64'h0);
        check("R10 digits after reset", digits, 64'h0);
        probe(7'h00, a);  check("R10 addr back to 0", {63'h0, a}, 64'h1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule